// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic stage of a small 8-bit processor. It takes one operation per request: an opcode, two operands (a register value or an immediate placed on the second operand), a 3-bit index and, for the two word operations, a small immediate. It returns a byte result and updates an internal 8-bit status register. Every operation has its own set of flags it may touch. All other flags keep their values, so flag-based branches can follow a chain of operations.

Most operations complete in one cycle. The two word operations treat `a_i` as the low byte and `b_i` as the high byte of a 16-bit pair, and they add or subtract an unsigned immediate. They take two cycles: the low byte is computed in the cycle of acceptance and the high byte in the next. While the high byte is being formed, `in_ready_o` is low and any request is dropped.

Status register bit positions: C=0, Z=1, N=2, V=3, S=4, H=5, T=6, U=7 (a spare flag that only set and clear reach). Opcode encoding on `op_i`: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 negate, 5 and, 6 or, 7 xor, 8 increment, 9 decrement, 10 invert, 11 shift left, 12 shift right logical, 13 rotate left through C, 14 rotate right through C, 15 shift right arithmetic, 16 nibble swap, 17 flag set, 18 flag clear, 19 bit to T, 20 T to bit, 21 word add, 22 word subtract.

Top module: `alu8_flags_core`

## Requirements
- R1: After reset the status register reads 0x00, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: Add (0) and add with carry (1) return a+b(+C) mod 256. They set C to the carry out of bit 7 and H to the carry out of bit 3. V is set on signed overflow, N is bit 7, Z means a zero result, and S is N xor V.
- R3: Subtract (2), subtract with carry (3) and negate (4, computes 0-a) return the difference. They set C and H to the borrows out of bits 7 and 3, and set V, N and S as for add. Z is set on a zero result, except for opcode 3, which sets Z only when the result is zero and Z was already 1.
- R4: And, or, xor, increment and decrement write only Z, N, V and S. V is 0 for the three logical operations. Increment sets V when the operand was 0x7F, and decrement sets V when the operand was 0x80. C and H are unchanged.
- R5: Invert (10) returns 0xFF minus a, sets C to 1 and V to 0, and writes Z, N and S.
- R6: For the shifts and rotates (11 to 15), C receives the bit shifted out. The rotates insert the old C at the opposite end, and the arithmetic right shift keeps bit 7. Z and N follow the result, V is N xor C, and S is N xor V. H is unchanged.
- R7: Nibble swap (16) exchanges bits 7..4 with bits 3..0 and leaves all flags unchanged.
- R8: Flag set (17) and flag clear (18) change only the status bit selected by `sel_i`. The result equals a.
- R9: Bit to T (19) copies a[`sel_i`] into T only. T to bit (20) returns a with bit `sel_i` replaced by T and changes no flag.
- R10: Word add (21) and word subtract (22) compute {b,a} ± imm on 16 bits. `out_valid_o` and the result pair appear two cycles after acceptance. C is the carry or borrow out of bit 15, Z means a 16-bit zero, N is bit 15, V is signed overflow and S is N xor V. H and T are unchanged.
- R11: A request presented while `in_ready_o` is low is not accepted and has no effect on results or flags.
- R12: A byte operation accepted at one clock edge gives `out_valid_o`=1 and its result after that same edge, with `res_hi_o`=0.
- R13: Whenever an operation writes both N and V, S equals N xor V afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Request present |
| op_i | input | 5 | Opcode |
| a_i | input | 8 | First operand; low byte of a word pair |
| b_i | input | 8 | Second operand or immediate; high byte of a word pair |
| imm_i | input | 6 | Unsigned immediate for word operations |
| sel_i | input | 3 | Flag index or bit index |
| in_ready_o | output | 1 | Low while a word operation is finishing |
| out_valid_o | output | 1 | Result valid for one cycle |
| res_o | output | 8 | Byte result or low byte of the word result |
| res_hi_o | output | 8 | High byte of the word result, else 0 |
| flags_o | output | 8 | Status register |

## Verification
The second cycle of a word operation can coincide with a new request that arrives at once behind it. The bench provokes this by driving a word operation and then holding a second request for the very next cycle. The outcome is judged by comparing the results and flags against a model in which that second request never happened. It can also coincide with a flag set or clear that carries the same index as a flag the word operation writes. In that case the word operation's flags must survive unchanged.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   localparam int OP_W   = 5;
   localparam int NFLAGS = 8;
   // status register bit positions (flag set/clear index decodes these)
   localparam int FC = 0;
   localparam int FZ = 1;
   localparam int FN = 2;
   localparam int FV = 3;
   localparam int FS = 4;
   localparam int FH = 5;
   localparam int FT = 6;
   localparam int FU = 7;

   typedef enum logic [OP_W-1:0] {
      OP_ADD   = 5'd0,
      OP_ADDC  = 5'd1,
      OP_SUB   = 5'd2,
      OP_SUBC  = 5'd3,
      OP_NEG   = 5'd4,
      OP_AND   = 5'd5,
      OP_OR    = 5'd6,
      OP_XOR   = 5'd7,
      OP_INC   = 5'd8,
      OP_DEC   = 5'd9,
      OP_NOT   = 5'd10,
      OP_SHL   = 5'd11,
      OP_SHR   = 5'd12,
      OP_ROL   = 5'd13,
      OP_ROR   = 5'd14,
      OP_ASR   = 5'd15,
      OP_SWAP  = 5'd16,
      OP_FSET  = 5'd17,
      OP_FCLR  = 5'd18,
      OP_TSTO  = 5'd19,
      OP_TLOAD = 5'd20,
      OP_WADD  = 5'd21,
      OP_WSUB  = 5'd22
   } alu_op_e;

   function automatic logic is_word_op(logic [OP_W-1:0] op);
      return (op == OP_WADD) || (op == OP_WSUB);
   endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,   // carry in for add, borrow in for subtract
   input  logic         sub,
   output logic [W-1:0] r,
   output logic         c,     // carry out or borrow out
   output logic         h,     // carry or borrow out of the low half
   output logic         v
);
   localparam int HB = W / 2;

   logic [W-1:0] y_eff;
   logic         ci;
   logic [W:0]   full;
   logic [HB:0]  low;

   always_comb begin
      y_eff = sub ? ~y : y;
      ci    = sub ? ~cin : cin;
      full  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, ci};
      low   = {1'b0, x[HB-1:0]} + {1'b0, y_eff[HB-1:0]} + {{HB{1'b0}}, ci};
      r     = full[W-1:0];
      c     = sub ? ~full[W] : full[W];
      h     = sub ? ~low[HB] : low[HB];
      v     = (x[W-1] == y_eff[W-1]) && (r[W-1] != x[W-1]);
   end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift import alu8_pkg::*; #(
   parameter int W = 8
) (
   input  alu_op_e      op,
   input  logic [W-1:0] a,
   input  logic         cin,
   output logic [W-1:0] r,
   output logic         cout
);
   always_comb begin
      r    = a;
      cout = cin;
      unique case (op)
         OP_SHL: begin r = {a[W-2:0], 1'b0};   cout = a[W-1]; end
         OP_SHR: begin r = {1'b0, a[W-1:1]};   cout = a[0];   end
         OP_ROL: begin r = {a[W-2:0], cin};    cout = a[W-1]; end
         OP_ROR: begin r = {cin, a[W-1:1]};    cout = a[0];   end
         OP_ASR: begin r = {a[W-1], a[W-1:1]}; cout = a[0];   end
         default: ;
      endcase
   end
endmodule

// File: rtl/alu8_byteops.sv
module alu8_byteops import alu8_pkg::*; #(
   parameter int W = 8
) (
   input  alu_op_e           op,
   input  logic [W-1:0]      a,
   input  logic [W-1:0]      b,
   input  logic [2:0]        sel,
   input  logic [NFLAGS-1:0] f,
   output logic [W-1:0]      r,
   output logic [NFLAGS-1:0] nf,
   output logic [NFLAGS-1:0] mask
);
   localparam int HB = W / 2;
   localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};
   localparam logic [NFLAGS-1:0] M_ARITH = NFLAGS'((1 << FC) | (1 << FZ) | (1 << FN) |
                                                  (1 << FV) | (1 << FS) | (1 << FH));
   localparam logic [NFLAGS-1:0] M_ZNVS  = NFLAGS'((1 << FZ) | (1 << FN) | (1 << FV) | (1 << FS));
   localparam logic [NFLAGS-1:0] M_CZNVS = M_ZNVS | NFLAGS'(1 << FC);

   logic [W-1:0] as_x, as_y, as_r, sh_r, sw_r;
   logic         as_cin, as_sub, as_c, as_h, as_v, sh_c;

   always_comb begin
      as_sub = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_NEG);
      as_x   = (op == OP_NEG) ? '0 : a;
      as_y   = (op == OP_NEG) ? a : b;
      as_cin = ((op == OP_ADDC) || (op == OP_SUBC)) ? f[FC] : 1'b0;
   end

   alu8_addsub #(.W(W)) u_addsub (
      .x(as_x), .y(as_y), .cin(as_cin), .sub(as_sub),
      .r(as_r), .c(as_c), .h(as_h), .v(as_v)
   );

   alu8_shift #(.W(W)) u_shift (
      .op(op), .a(a), .cin(f[FC]), .r(sh_r), .cout(sh_c)
   );

   for (genvar i = 0; i < HB; i++) begin : g_swap
      assign sw_r[i]      = a[i + HB];
      assign sw_r[i + HB] = a[i];
   end

   always_comb begin
      r    = a;
      nf   = f;
      mask = '0;
      unique case (op)
         OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_NEG: begin
            r      = as_r;
            nf[FC] = as_c;
            nf[FH] = as_h;
            nf[FV] = as_v;
            mask   = M_ARITH;
         end
         OP_AND: begin r = a & b; nf[FV] = 1'b0; mask = M_ZNVS; end
         OP_OR:  begin r = a | b; nf[FV] = 1'b0; mask = M_ZNVS; end
         OP_XOR: begin r = a ^ b; nf[FV] = 1'b0; mask = M_ZNVS; end
         OP_INC: begin r = a + W'(1); nf[FV] = (r == MSB_ONLY);  mask = M_ZNVS; end
         OP_DEC: begin r = a - W'(1); nf[FV] = (r == ~MSB_ONLY); mask = M_ZNVS; end
         OP_NOT: begin
            r      = ~a;
            nf[FC] = 1'b1;
            nf[FV] = 1'b0;
            mask   = M_CZNVS;
         end
         OP_SHL, OP_SHR, OP_ROL, OP_ROR, OP_ASR: begin
            r      = sh_r;
            nf[FC] = sh_c;
            nf[FV] = sh_r[W-1] ^ sh_c;
            mask   = M_CZNVS;
         end
         OP_SWAP:  r = sw_r;
         OP_FSET:  begin nf[sel] = 1'b1; mask[sel] = 1'b1; end
         OP_FCLR:  begin nf[sel] = 1'b0; mask[sel] = 1'b1; end
         OP_TSTO:  begin nf[FT] = a[sel]; mask[FT] = 1'b1; end
         OP_TLOAD: r[sel] = f[FT];
         default: ;
      endcase
      if (mask[FZ] && mask[FN]) begin
         nf[FN] = r[W-1];
         nf[FZ] = (op == OP_SUBC) ? ((~|r) & f[FZ]) : ~|r;
      end
      if (mask[FN] && mask[FV]) nf[FS] = nf[FN] ^ nf[FV];
   end
endmodule

// File: rtl/alu8_flags_core.sv
module alu8_flags_core import alu8_pkg::*; #(
   parameter int W         = 8,
   parameter int IMM_W     = 6,
   parameter bit HCARRY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid_i,
   input  logic [OP_W-1:0]   op_i,
   input  logic [W-1:0]      a_i,
   input  logic [W-1:0]      b_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [2:0]        sel_i,
   output logic              in_ready_o,
   output logic              out_valid_o,
   output logic [W-1:0]      res_o,
   output logic [W-1:0]      res_hi_o,
   output logic [NFLAGS-1:0] flags_o
);
   if (W < 8 || (W % 2) != 0) begin : g_bad_w
      $error("alu8_flags_core: W must be even and at least 8");
   end
   if (IMM_W < 1 || IMM_W >= W) begin : g_bad_imm
      $error("alu8_flags_core: IMM_W must lie in 1..W-1");
   end

   alu_op_e           op;
   logic [NFLAGS-1:0] flags_q, b_nf, b_mask, eff_mask;
   logic [W-1:0]      b_res, res_q, res_hi_q;
   logic              vld_q, wbusy_q, w_cy_q, w_sub_q;
   logic [W-1:0]      w_lo_q, w_hi_q;
   logic [W-1:0]      lo_r, hi_r;
   logic              lo_c, lo_h, lo_v, hi_c, hi_h, hi_v;

   assign op = alu_op_e'(op_i);

   alu8_byteops #(.W(W)) u_byte (
      .op(op), .a(a_i), .b(b_i), .sel(sel_i), .f(flags_q),
      .r(b_res), .nf(b_nf), .mask(b_mask)
   );

   if (HCARRY_EN) begin : g_hc_on
      assign eff_mask = b_mask;
   end else begin : g_hc_off
      assign eff_mask = b_mask & ~NFLAGS'(1 << FH);
   end

   // word path: low byte at acceptance, high byte in the following cycle
   alu8_addsub #(.W(W)) u_wlo (
      .x(a_i), .y({{(W-IMM_W){1'b0}}, imm_i}), .cin(1'b0), .sub(op == OP_WSUB),
      .r(lo_r), .c(lo_c), .h(lo_h), .v(lo_v)
   );

   alu8_addsub #(.W(W)) u_whi (
      .x(w_hi_q), .y('0), .cin(w_cy_q), .sub(w_sub_q),
      .r(hi_r), .c(hi_c), .h(hi_h), .v(hi_v)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q  <= '0;
         res_q    <= '0;
         res_hi_q <= '0;
         vld_q    <= 1'b0;
         wbusy_q  <= 1'b0;
         w_lo_q   <= '0;
         w_hi_q   <= '0;
         w_cy_q   <= 1'b0;
         w_sub_q  <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         if (wbusy_q) begin
            wbusy_q     <= 1'b0;
            vld_q       <= 1'b1;
            res_q       <= w_lo_q;
            res_hi_q    <= hi_r;
            flags_q[FC] <= hi_c;
            flags_q[FZ] <= (~|hi_r) & (~|w_lo_q);
            flags_q[FN] <= hi_r[W-1];
            flags_q[FV] <= hi_v;
            flags_q[FS] <= hi_r[W-1] ^ hi_v;
         end else if (in_valid_i) begin
            if (is_word_op(op_i)) begin
               wbusy_q <= 1'b1;
               w_lo_q  <= lo_r;
               w_hi_q  <= b_i;
               w_cy_q  <= lo_c;
               w_sub_q <= (op == OP_WSUB);
            end else begin
               vld_q    <= 1'b1;
               res_q    <= b_res;
               res_hi_q <= '0;
               flags_q  <= (flags_q & ~eff_mask) | (b_nf & eff_mask);
            end
         end
      end
   end

   assign in_ready_o  = ~wbusy_q;
   assign out_valid_o = vld_q;
   assign res_o       = res_q;
   assign res_hi_o    = res_hi_q;
   assign flags_o     = flags_q;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk import alu8_pkg::*; (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid_i,
   input logic [OP_W-1:0]   op_i,
   input logic [2:0]        sel_i,
   input logic              in_ready_o,
   input logic              out_valid_o,
   input logic [NFLAGS-1:0] flags_o
);
   logic acc;
   assign acc = in_valid_i && in_ready_o;

   p_swap_keeps_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc && op_i == OP_SWAP |=> flags_o == $past(flags_o));

   p_logic_keeps_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      acc && op_i >= OP_AND && op_i <= OP_DEC
      |=> flags_o[FC] == $past(flags_o[FC]) && flags_o[FH] == $past(flags_o[FH]));

   p_invert_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      acc && op_i == OP_NOT |=> flags_o[FC] && !flags_o[FV]);

   p_sign_rule_r13: assert property (@(posedge clk) disable iff (!rst_n)
      acc && op_i <= OP_ASR && op_i != OP_SWAP
      |=> flags_o[FS] == (flags_o[FN] ^ flags_o[FV]));

   p_subc_zero_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc && op_i == OP_SUBC && !flags_o[FZ] |=> !flags_o[FZ]);

   p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc && op_i == OP_FSET |=> flags_o[$past(sel_i)]);

   p_word_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      acc && is_word_op(op_i) |=> !in_ready_o && !out_valid_o);

   p_busy_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready_o |=> in_ready_o && out_valid_o && $stable(flags_o[FT]));

   p_byte_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !is_word_op(op_i) |=> out_valid_o);
endmodule

bind alu8_flags_core alu8_flags_chk chk_i (
   .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .op_i(op_i), .sel_i(sel_i),
   .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .flags_o(flags_o)
);

// File: tb/alu8_flags_core_tb_top.sv
module alu8_flags_core_tb_top;
   import alu8_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [4:0] op = '0;
   logic [7:0] a = '0, b = '0;
   logic [5:0] imm = '0;
   logic [2:0] sel = '0;
   logic       in_ready, out_valid;
   logic [7:0] res, res_hi, flags;

   int checks = 0, fails = 0, cyc = 0;

   // reference model state
   int    m_flags = 0, m_res = 0, m_hi = 0, m_valid = 0, m_busy = 0;
   int    m_wlo = 0, m_whi = 0, m_imm = 0, m_wsub = 0;
   string m_tag = "R1";

   always #10 clk = ~clk;

   alu8_flags_core dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .op_i(op), .a_i(a), .b_i(b),
      .imm_i(imm), .sel_i(sel), .in_ready_o(in_ready), .out_valid_o(out_valid),
      .res_o(res), .res_hi_o(res_hi), .flags_o(flags)
   );

   function automatic int gf(int fl, int idx);
      return (fl >> idx) & 1;
   endfunction
   function automatic int pf(int fl, int idx, int v);
      return (fl & ~(1 << idx)) | ((v & 1) << idx);
   endfunction
   function automatic int sx(int v);
      return (v > 127) ? v - 256 : v;
   endfunction

   task automatic model_byte(int o, int x, int y, int s);
      int r, cin, t, sv, nn, vv;
      int fl = m_flags;
      r = x;
      case (o)
         0, 1: begin
            cin = (o == 1) ? gf(fl, FC) : 0;
            t = x + y + cin; r = t & 255;
            fl = pf(fl, FC, t > 255);
            fl = pf(fl, FH, ((x & 15) + (y & 15) + cin) > 15);
            sv = sx(x) + sx(y) + cin;
            fl = pf(fl, FV, sv > 127 || sv < -128);
            fl = pf(fl, FZ, r == 0);
            m_tag = "R2/R13";
         end
         2, 3, 4: begin
            int p = x, q = y;
            if (o == 4) begin p = 0; q = x; end
            cin = (o == 3) ? gf(fl, FC) : 0;
            t = p - q - cin; r = t & 255;
            fl = pf(fl, FC, t < 0);
            fl = pf(fl, FH, ((p & 15) - (q & 15) - cin) < 0);
            sv = sx(p) - sx(q) - cin;
            fl = pf(fl, FV, sv > 127 || sv < -128);
            fl = pf(fl, FZ, (o == 3) ? (r == 0 && gf(fl, FZ) == 1) : (r == 0));
            m_tag = "R3/R13";
         end
         5, 6, 7, 8, 9: begin
            if (o == 5) r = x & y;
            if (o == 6) r = x | y;
            if (o == 7) r = x ^ y;
            if (o == 8) r = (x + 1) & 255;
            if (o == 9) r = (x + 255) & 255;
            vv = (o == 8) ? (x == 127) : (o == 9) ? (x == 128) : 0;
            fl = pf(fl, FV, vv);
            fl = pf(fl, FZ, r == 0);
            m_tag = "R4";
         end
         10: begin
            r = 255 - x;
            fl = pf(fl, FC, 1); fl = pf(fl, FV, 0); fl = pf(fl, FZ, r == 0);
            m_tag = "R5";
         end
         11, 12, 13, 14, 15: begin
            cin = gf(fl, FC);
            case (o)
               11: begin r = (x * 2) & 255;            t = x / 128; end
               12: begin r = x / 2;                    t = x % 2;   end
               13: begin r = ((x * 2) & 255) + cin;    t = x / 128; end
               14: begin r = x / 2 + cin * 128;        t = x % 2;   end
               default: begin r = x / 2 + (x & 128);   t = x % 2;   end
            endcase
            nn = r / 128;
            fl = pf(fl, FC, t); fl = pf(fl, FV, nn ^ t); fl = pf(fl, FZ, r == 0);
            m_tag = "R6";
         end
         16: begin r = ((x % 16) * 16) + (x / 16); m_tag = "R7"; end
         17: begin fl = pf(fl, s, 1); m_tag = "R8"; end
         18: begin fl = pf(fl, s, 0); m_tag = "R8"; end
         19: begin fl = pf(fl, FT, (x >> s) & 1); m_tag = "R9"; end
         20: begin r = gf(fl, FT) ? (x | (1 << s)) : (x & ~(1 << s)); m_tag = "R9"; end
         default: ;
      endcase
      if (o <= 15 && o != 16) begin
         nn = r / 128;
         fl = pf(fl, FN, nn);
         fl = pf(fl, FS, nn ^ gf(fl, FV));
      end
      m_flags = fl;
      m_res   = r;
      m_hi    = 0;
   endtask

   task automatic model_word();
      int w = m_whi * 256 + m_wlo;
      int w2, sin, sout, vv, fl = m_flags;
      w2 = m_wsub ? (w - m_imm) : (w + m_imm);
      fl = pf(fl, FC, (w2 < 0) || (w2 > 65535));
      if (w2 < 0) w2 += 65536;
      w2 &= 65535;
      sin = w / 32768; sout = w2 / 32768;
      vv = m_wsub ? (sin & ~sout & 1) : (~sin & sout & 1);
      fl = pf(fl, FV, vv); fl = pf(fl, FN, sout);
      fl = pf(fl, FS, sout ^ vv); fl = pf(fl, FZ, w2 == 0);
      m_flags = fl;
      m_res   = w2 % 256;
      m_hi    = w2 / 256;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_flags = 0; m_valid = 0; m_busy = 0; m_tag = "R1";
      end else begin
         m_valid = 0;
         if (m_busy != 0) begin
            model_word();
            m_busy = 0; m_valid = 1;
            m_tag = in_valid ? "R11" : "R10/R13";
         end else if (in_valid) begin
            if (op == 21 || op == 22) begin
               m_busy = 1; m_wlo = a; m_whi = b; m_imm = imm; m_wsub = (op == 22);
               m_tag = "R10";
            end else begin
               model_byte(op, a, b, sel);
               m_valid = 1;
            end
         end
      end
   end

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s act=%h exp=%h at cycle %0d", tag, what, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check("R12", "out_valid", out_valid, m_valid);
         check("R10", "in_ready", in_ready, (m_busy == 0));
         check(m_tag, "flags", flags, m_flags);
         if (m_valid != 0) begin
            check(m_tag, "res", res, m_res);
            check(m_tag, "res_hi", res_hi, m_hi);
         end
      end
   end

   task automatic drive(int o, int x, int y, int i, int s);
      @(negedge clk);
      in_valid = 1'b1; op = 5'(o); a = 8'(x); b = 8'(y); imm = 6'(i); sel = 3'(s);
   endtask
   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask
   task automatic issue(int o, int x, int y, int i, int s);
      drive(o, x, y, i, s);
      idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values
      check("R1", "flags after reset", flags, 0);
      check("R1", "out_valid after reset", out_valid, 0);
      check("R1", "in_ready after reset", in_ready, 1);
      rst_n = 1'b1;
      // R2 add corners
      issue(0, 8'h80, 8'h80, 0, 0);
      issue(0, 8'h0F, 8'h01, 0, 0);
      issue(0, 8'h7F, 8'h01, 0, 0);
      issue(1, 8'hFF, 8'h00, 0, 0);
      // R3 subtract, borrow chain with sticky Z, negate
      issue(2, 8'h00, 8'h01, 0, 0);
      issue(2, 8'h12, 8'h12, 0, 0);
      issue(3, 8'h00, 8'h00, 0, 0);
      issue(2, 8'h80, 8'h01, 0, 0);
      issue(4, 8'h80, 0, 0, 0);
      issue(4, 8'h00, 0, 0, 0);
      issue(18, 0, 0, 0, FZ);
      issue(3, 8'h05, 8'h05, 0, 0);
      // R4 logical, increment, decrement
      issue(17, 0, 0, 0, FC);
      issue(8, 8'h7F, 0, 0, 0);
      issue(9, 8'h80, 0, 0, 0);
      issue(5, 8'hF0, 8'h0F, 0, 0);
      issue(7, 8'hAA, 8'h55, 0, 0);
      // R5 invert
      issue(10, 8'hFF, 0, 0, 0);
      // R6 shifts and rotates
      issue(13, 8'h80, 0, 0, 0);
      issue(13, 8'h01, 0, 0, 0);
      issue(14, 8'h01, 0, 0, 0);
      issue(15, 8'h81, 0, 0, 0);
      issue(12, 8'h01, 0, 0, 0);
      // R7 swap
      issue(16, 8'h3C, 0, 0, 0);
      // R8 set and clear every index
      for (int k = 0; k < 8; k++) issue(17, 8'h5A, 0, 0, k);
      for (int k = 0; k < 8; k++) issue(18, 8'h5A, 0, 0, k);
      // R9 T store and load
      issue(19, 8'h08, 0, 0, 3);
      issue(20, 8'h00, 0, 0, 7);
      issue(19, 8'h08, 0, 0, 2);
      issue(20, 8'hFF, 0, 0, 0);
      // R10 word operations
      issue(21, 8'hFF, 8'hFF, 1, 0);
      issue(21, 8'hFF, 8'h7F, 1, 0);
      issue(22, 8'h00, 8'h00, 1, 0);
      issue(22, 8'h00, 8'h80, 1, 0);
      // R11 request behind a word operation is dropped
      drive(21, 8'h10, 8'h00, 5, 0);
      drive(17, 0, 0, 0, FC);
      idle();
      drive(22, 8'h00, 8'h01, 1, 0);
      drive(10, 8'h00, 0, 0, 0);
      idle();
      // mixed traffic with back-to-back requests
      for (int n = 0; n < 600; n++) begin
         drive($urandom_range(0, 22), $urandom_range(0, 255), $urandom_range(0, 255),
               $urandom_range(0, 63), $urandom_range(0, 7));
         if ($urandom_range(0, 3) == 0) idle();
      end
      idle();
      repeat (4) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      wait (cyc > 150000);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end act=%0d exp=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule